// File: doc/BRIEF.md
# Guarded Move Transport Controller

This block issues one instruction word per cycle for a processor whose only operation is a data transfer. Each word carries several parallel move slots. Every slot names a source address, a destination address and a three-bit guard selector. The guard is a boolean function of two compare flags held inside the block. Every slot whose guard is true reads its source and writes its destination in the same cycle, and all sources are read before any write lands. The moves that take place are presented at the ports so that function-unit registers outside the block can take them.

The register address space has general registers at the low addresses and two special locations at the top. The address just below the top is the program counter. A move into it is an absolute jump, and reading it returns the address of the current instruction. The top address is the displacement register. A move into it is a relative jump. Reading it returns the value on the function-unit result input. Both jump kinds take effect after two delay slots. The compare flags are loaded from a compare unit outside the block. A guard sees the new flags only from the next instruction onward.

Top module: `move_guard_ctrl`

## Requirements
- R1: After reset the program counter is 0, all general registers read 0, both compare flags are 0, and no move is enabled while `instr_valid` is low.
- R2: The guard selector (slot bits [2:0]) enables the move as follows: 0 always, 1 never, 2 c0, 3 c1, 4 c0 AND c1, 5 c0 OR c1, 6 NOT c0, 7 NOT c1. Here c0 is flag bit 0 and c1 is flag bit 1.
- R3: Flags loaded through `flag_we` in a cycle do not affect the guards of that cycle's instruction. They apply from the next instruction onward.
- R4: All slots read their sources before any write takes effect, so two slots that move r1 to r2 and r2 to r1 exchange the two values. A write to a general register is visible to reads from the next instruction onward.
- R5: Source address 14 returns the program counter of the current instruction. Source address 15 returns `fu_result`. Addresses 0 to 13 are general registers. In a slot, bits [6:3] are the source and bits [10:7] are the destination. Slot k occupies instruction bits [11k+10:11k].
- R6: When two enabled slots write the same destination in one instruction, `conflict` is high during that instruction and the higher-numbered slot's value is the one stored.
- R7: A move to address 14 at instruction address P sets the fetch sequence to P+1, P+2 and then the moved value.
- R8: A move to address 15 at instruction address P sets the fetch sequence to P+1, P+2 and then P plus the moved value, modulo 2^16.
- R9: The program counter advances only on cycles with `instr_valid` high. Idle cycles neither advance it nor use up a delay slot.
- R10: A jump issued from a delay slot of a pending jump is ignored. The first jump's target is reached and fetching continues sequentially after it.
- R11: A move to the program counter whose guard is false does not change the sequential flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 22 | Two move slots, each {dst[3:0], src[3:0], guard[2:0]} |
| fu_result | input | 16 | Function-unit result, readable at source address 15 |
| flag_we | input | 1 | Load the compare flags at the end of this cycle |
| flag_in | input | 2 | New compare flags {c1, c0} |
| pc | output | 16 | Address of the instruction being presented |
| mv_en | output | 2 | Per slot: the move takes place this cycle |
| mv_dst | output | 8 | Per slot destination address, slot k in [4k+3:4k] |
| mv_data | output | 32 | Per slot moved value, slot k in [16k+15:16k] |
| conflict | output | 1 | Two enabled slots share a destination |

## Verification
The bench tries all eight guard codes under three flag settings, and it loads flags in the same cycle as a guarded move. A design that forwarded new flags early would enable that move. Two tests target the ordering of the parallel slots. An exchange between two registers shows whether reads happen before writes: if they do not, both registers end up with the same value. A same-destination pair in two slots shows which slot wins and whether `conflict` rises. The jump tests count delay slots through idle cycles, through a second jump inside a delay slot, and through a jump whose guard is false. An off-by-one or a jump that re-arms shows up as the wrong fetch address. The relative jump uses a negative displacement, so a design that adds to the wrong base or drops the carry lands on the wrong target.

// File: rtl/move_guard_ctrl.sv
module move_guard_ctrl #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int NSLOT  = 2,
  parameter int NDELAY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  instr_valid,
  input  logic [NSLOT*(3+2*AW)-1:0] instr,
  input  logic [DW-1:0]         fu_result,
  input  logic                  flag_we,
  input  logic [1:0]            flag_in,
  output logic [DW-1:0]         pc,
  output logic [NSLOT-1:0]      mv_en,
  output logic [NSLOT*AW-1:0]   mv_dst,
  output logic [NSLOT*DW-1:0]   mv_data,
  output logic                  conflict
);
  localparam int SW        = 3 + 2*AW;
  localparam int NREG      = 1 << AW;
  localparam int NGPR      = NREG - 2;
  localparam int PC_ADDR   = NREG - 2;
  localparam int DISP_ADDR = NREG - 1;
  localparam int CW        = $clog2(NDELAY + 1);

  logic [DW-1:0] gpr [NGPR];
  logic [1:0]    flags;
  logic [DW-1:0] pc_q, tgt_q;
  logic [CW-1:0] cnt_q;

  logic [2:0]    sg   [NSLOT];
  logic [AW-1:0] ssrc [NSLOT];
  logic [AW-1:0] sdst [NSLOT];
  logic [DW-1:0] sdat [NSLOT];
  logic          jmp;
  logic [DW-1:0] jtgt;

  assign pc = pc_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic gok;
    assign sg[s]   = instr[s*SW +: 3];
    assign ssrc[s] = instr[s*SW+3 +: AW];
    assign sdst[s] = instr[s*SW+3+AW +: AW];

    always_comb begin
      case (sg[s])
        3'd0: gok = 1'b1;
        3'd1: gok = 1'b0;
        3'd2: gok = flags[0];
        3'd3: gok = flags[1];
        3'd4: gok = flags[0] & flags[1];
        3'd5: gok = flags[0] | flags[1];
        3'd6: gok = ~flags[0];
        default: gok = ~flags[1];
      endcase
    end

    assign sdat[s] = (ssrc[s] == AW'(PC_ADDR))   ? pc_q :
                     (ssrc[s] == AW'(DISP_ADDR)) ? fu_result :
                                                   gpr[ssrc[s]];

    assign mv_en[s]            = instr_valid & gok;
    assign mv_dst[s*AW +: AW]  = sdst[s];
    assign mv_data[s*DW +: DW] = sdat[s];

    AST_NEVER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (sg[s] == 3'd1) |-> !mv_en[s]); // R2
  end

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      for (int j = i + 1; j < NSLOT; j++)
        if (mv_en[i] && mv_en[j] && sdst[i] == sdst[j]) conflict = 1'b1;
  end

  always_comb begin
    jmp  = 1'b0;
    jtgt = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (mv_en[i] && sdst[i] == AW'(PC_ADDR)) begin
        jmp  = 1'b1;
        jtgt = sdat[i];
      end else if (mv_en[i] && sdst[i] == AW'(DISP_ADDR)) begin
        jmp  = 1'b1;
        jtgt = pc_q + sdat[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NGPR; r++) gpr[r] <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++)
        if (mv_en[i] && sdst[i] < AW'(NGPR)) gpr[sdst[i]] <= sdat[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flags <= 2'b00;
    else if (flag_we) flags <= flag_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      tgt_q <= '0;
      cnt_q <= '0;
    end else if (instr_valid) begin
      if (cnt_q == CW'(1)) pc_q <= tgt_q;
      else                 pc_q <= pc_q + 1'b1;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (jmp) begin
        cnt_q <= CW'(NDELAY);
        tgt_q <= jtgt;
      end
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc)); // R9
  AST_PC_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cnt_q == CW'(1)) |=> pc == $past(tgt_q)); // R7
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R10
  AST_CONFLICT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $countones(mv_en) >= 2); // R6
endmodule

// File: tb/move_guard_ctrl_bench.sv
`timescale 1ns/1ps
module move_guard_ctrl_bench;
  localparam int DW = 16, AW = 4, SW = 3 + 2*AW;

  logic clk = 1'b0, rst_n = 1'b0, instr_valid = 1'b0, flag_we = 1'b0;
  logic [2*SW-1:0] instr = '0;
  logic [DW-1:0]   fu_result = '0;
  logic [1:0]      flag_in = '0;
  logic [DW-1:0]   pc;
  logic [1:0]      mv_en;
  logic [2*AW-1:0] mv_dst;
  logic [2*DW-1:0] mv_data;
  logic            conflict;
  int checks = 0, errors = 0;

  move_guard_ctrl u_move_guard_ctrl (.clk, .rst_n, .instr_valid, .instr, .fu_result,
    .flag_we, .flag_in, .pc, .mv_en, .mv_dst, .mv_data, .conflict);

  always #2.5 clk = ~clk;

  function automatic logic [SW-1:0] sl(input logic [2:0] g, input logic [3:0] s, input logic [3:0] d);
    return {d, s, g};
  endfunction
  localparam logic [SW-1:0] NOP = {4'd0, 4'd0, 3'd1};

  function automatic logic gexp(input int g, input logic c0, input logic c1);
    case (g)
      0: return 1'b1; 1: return 1'b0; 2: return c0; 3: return c1;
      4: return c0 && c1; 5: return c0 || c1; 6: return !c0; default: return !c1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2*SW-1:0] w, input logic [DW-1:0] fr,
                      input logic fwe = 1'b0, input logic [1:0] fin = 2'b00);
    @(negedge clk);
    instr_valid = 1'b1; instr = w; fu_result = fr; flag_we = fwe; flag_in = fin;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0; instr = '0; flag_we = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 0);
    chk("R1 idle mv_en", mv_en, 0);
    step({NOP, sl(0, 1, 0)}, 0);
    chk("R1 gpr zero", mv_data[15:0], 0);
    chk("R1 first pc", pc, 0);
    step({NOP, sl(2, 15, 0)}, 0);
    chk("R1 flags zero", mv_en[0], 0);
  endtask

  task automatic t_guards();
    logic [1:0] f [3] = '{2'b01, 2'b10, 2'b11};
    step({NOP, sl(2, 15, 0)}, 0, 1'b1, 2'b01);
    chk("R3 flags not yet visible", mv_en[0], 0);
    for (int k = 0; k < 3; k++) begin
      if (k > 0) step({NOP, NOP}, 0, 1'b1, f[k]);
      for (int g = 0; g < 8; g++) begin
        step({NOP, sl(3'(g), 15, 0)}, 0);
        chk($sformatf("R2 guard %0d flags %b", g, f[k]), mv_en[0], gexp(g, f[k][0], f[k][1]));
      end
    end
  endtask

  task automatic t_parallel();
    step({NOP, sl(0, 15, 1)}, 16'h1111);
    step({NOP, sl(0, 15, 2)}, 16'h2222);
    step({sl(0, 2, 1), sl(0, 1, 2)}, 0);
    chk("R4 swap read slot0", mv_data[15:0], 16'h1111);
    chk("R4 swap read slot1", mv_data[31:16], 16'h2222);
    step({sl(0, 2, 3), sl(0, 1, 4)}, 0);
    chk("R4 swapped r1", mv_data[15:0], 16'h2222);
    chk("R4 swapped r2", mv_data[31:16], 16'h1111);
    step({NOP, sl(0, 14, 5)}, 16'h5555);
    chk("R5 pc source", mv_data[15:0], pc);
    chk("R5 dst field", mv_dst[3:0], 5);
    step({NOP, sl(0, 15, 5)}, 16'h5A5A);
    chk("R5 fu_result source", mv_data[15:0], 16'h5A5A);
  endtask

  task automatic t_conflict();
    step({sl(0, 1, 6), sl(0, 15, 6)}, 16'hAAAA);
    chk("R6 conflict high", conflict, 1);
    step({NOP, sl(0, 6, 7)}, 0);
    chk("R6 higher slot wins", mv_data[15:0], 16'h2222);
    chk("R6 conflict low", conflict, 0);
    step({sl(1, 1, 6), sl(0, 15, 6)}, 16'hBBBB);
    chk("R6 guarded-off no conflict", conflict, 0);
    step({NOP, sl(0, 6, 7)}, 0);
    chk("R6 single writer", mv_data[15:0], 16'hBBBB);
  endtask

  task automatic t_abs_jump();
    logic [DW-1:0] p;
    step({NOP, sl(0, 15, 14)}, 16'h0040);
    p = pc;
    step({NOP, NOP}, 0); chk("R7 delay slot 1", pc, p + 1);
    step({NOP, NOP}, 0); chk("R7 delay slot 2", pc, p + 2);
    step({NOP, NOP}, 0); chk("R7 target", pc, 16'h0040);
    step({NOP, NOP}, 0); chk("R7 after target", pc, 16'h0041);
  endtask

  task automatic t_rel_jump();
    logic [DW-1:0] q;
    step({NOP, sl(0, 15, 15)}, 16'h0010);
    q = pc;
    step({NOP, NOP}, 0); chk("R8 delay slot 1", pc, q + 1);
    step({NOP, NOP}, 0); step({NOP, NOP}, 0);
    chk("R8 forward target", pc, q + 16'h0010);
    step({NOP, sl(0, 15, 15)}, 16'hFFF0);
    q = pc;
    step({NOP, NOP}, 0); step({NOP, NOP}, 0); step({NOP, NOP}, 0);
    chk("R8 backward target", pc, q - 16'd16);
  endtask

  task automatic t_stall();
    logic [DW-1:0] p;
    step({NOP, sl(0, 15, 14)}, 16'h0080);
    p = pc;
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R9 pc holds while idle", pc, p + 1);
    end
    step({NOP, NOP}, 0); chk("R9 slot 1 after idle", pc, p + 1);
    step({NOP, NOP}, 0); chk("R9 slot 2", pc, p + 2);
    idle();
    step({NOP, NOP}, 0); chk("R9 target after idle", pc, 16'h0080);
  endtask

  task automatic t_ignore();
    logic [DW-1:0] p;
    step({NOP, sl(0, 15, 14)}, 16'h0100);
    p = pc;
    step({NOP, sl(0, 15, 14)}, 16'h0200); chk("R10 slot 1", pc, p + 1);
    step({NOP, NOP}, 0); chk("R10 slot 2", pc, p + 2);
    step({NOP, NOP}, 0); chk("R10 first target", pc, 16'h0100);
    step({NOP, NOP}, 0); chk("R10 no second jump", pc, 16'h0101);
    step({NOP, NOP}, 0); chk("R10 still sequential", pc, 16'h0102);
  endtask

  task automatic t_guarded_jump();
    logic [DW-1:0] p;
    step({NOP, sl(6, 15, 14)}, 16'h0300);
    p = pc;
    chk("R11 jump move disabled", mv_en[0], 0);
    step({NOP, NOP}, 0); step({NOP, NOP}, 0); step({NOP, NOP}, 0);
    chk("R11 sequential flow", pc, p + 3);
  endtask

  initial begin
    #(5.0 * 50000);
    errors++;
    $display("FAIL watchdog expired actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_guards();
    t_parallel();
    t_conflict();
    t_abs_jump();
    t_rel_jump();
    t_stall();
    t_ignore();
    t_guarded_jump();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule